// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits at the top of an error reporting tree, in a root port. Each cycle it can take one error message that has already passed the bridge gating below it. A message is either correctable, uncorrectable non-fatal or uncorrectable fatal, and it carries a 16-bit requester source ID. The block keeps a root error status register. That register records which classes of error have arrived. It also records whether a class has been seen more than once, and whether the first uncorrectable error was fatal. The block captures the source ID of the first correctable error and of the first uncorrectable error.

Software reaches three locations through a simple configuration port. The status register has write-one-to-clear report bits and a read-only interrupt vector field. The command register holds three reporting enables. A third register packs both captured source IDs. The block signals an interrupt in one of three ways. It can drive a level on the legacy INTx wire. It can pulse a one-cycle MSI request or a one-cycle MSI-X request. In every case the current vector field goes with the request.

Top module: `rpe_collector`

## Requirements
- R1: After a synchronous active-low reset, status, command and both source fields read zero, and `intx_level`, `msi_req` and `msix_req` are low.
- R2: A correctable message (`msg_sev`=0) sets status bit 0. The message's source ID is copied into bits 15:0 of the source register (`cfg_addr`=2) only when bit 0 was clear beforehand. If bit 0 was already set, status bit 1 (multiple correctable) is set instead.
- R3: An uncorrectable message (`msg_sev`=1 non-fatal or 2 fatal) sets status bit 2. Its source ID is copied into bits 31:16 of the source register only when bit 2 was clear beforehand. If bit 2 was already set, status bit 3 (multiple uncorrectable) is set instead.
- R4: A non-fatal message sets status bit 5. A fatal message sets status bit 6. A fatal message also sets status bit 4 (first was fatal), but only when bit 2 was clear before that message.
- R5: Writing a one to any of status bits 6:0 (`cfg_addr`=0) clears it, and writing a zero leaves it unchanged. Status bits 31:27 show the vector field. Writes do not change it; it loads from `vec_in` when `vec_load` is high. `irq_vector` always shows it.
- R6: The command register (`cfg_addr`=1) holds the enables in bits 2:0: correctable, non-fatal, fatal. It reads back what was written, and its other bits read zero.
- R7: A message requests an interrupt only when both of these hold: the enable for its severity is set, and no enabled status class (bit 0 under enable 0, bit 5 under enable 1, bit 6 under enable 2) was already set before the message.
- R8: An interrupt request goes out as a one-cycle `msix_req` pulse when `msix_en` is high. Otherwise it goes out as a one-cycle `msi_req` pulse when `msi_en` is high. If neither is high, `intx_level` is driven high.
- R9: When the command register is written while `msi_en` and `msix_en` are both low, `intx_level` becomes the OR, over the three classes, of enable AND status class bit. The new enables are used.
- R10: When the command register is written while MSI or MSI-X is enabled, a single request pulse is sent only if no class was enabled-and-set under the old enables and at least one class is under the new ones.
- R11: If a message and a status clear-write land in the same cycle, the message's first/multiple decisions use the status from before the write. The bits the message sets survive the clear.
- R12: A message with `msg_sev`=3 changes no state and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 ignored |
| msg_src | input | 16 | Source ID of the message |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 status, 1 command, 2 source IDs |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| vec_load | input | 1 | Load the vector field from `vec_in` |
| vec_in | input | 5 | New vector field value |
| msi_en | input | 1 | MSI delivery enabled |
| msix_en | input | 1 | MSI-X delivery enabled (wins over MSI) |
| intx_level | output | 1 | Legacy interrupt level |
| msi_req | output | 1 | One-cycle MSI request |
| msix_req | output | 1 | One-cycle MSI-X request |
| irq_vector | output | 5 | Vector field sent with a request |

## Verification
Most internal errors show at the ports one cycle after the message or write that causes them. Suppose a first/multiple flag or the captured source ID is wrong. The status and source registers then read wrongly at once, and every later message compares against that stale flag. Suppose instead that the enabled-status condition is computed from the wrong status or command value. This shows as a missing or extra request pulse, or as a wrong INTx level, in the cycle right after the event. It becomes visible only when the status pattern and the enables overlap in the right way. For that reason the bench sweeps every class pattern against every old and new enable value, in each delivery mode.

// File: rtl/rpe_pkg.sv
// Shared types for the root port error status collector.
package rpe_pkg;

    // Message severity encoding on the msg_sev port.
    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_NONE     = 2'd3
    } sev_e;

    // Report bits of the status register, bit 0 at the bottom.
    typedef struct packed {
        logic fat;    // bit 6 fatal received
        logic nf;     // bit 5 non-fatal received
        logic ffat;   // bit 4 first uncorrectable was fatal
        logic munc;   // bit 3 multiple uncorrectable
        logic unc;    // bit 2 uncorrectable received
        logic mcor;   // bit 1 multiple correctable
        logic cor;    // bit 0 correctable received
    } rpt_t;

    localparam int RPT_W = $bits(rpt_t);
    localparam int CMD_W = 3;

    localparam logic [1:0] ADDR_STATUS = 2'd0;
    localparam logic [1:0] ADDR_CMD    = 2'd1;
    localparam logic [1:0] ADDR_SRC    = 2'd2;

    // Status classes in command-enable order: {fatal, non-fatal, correctable}.
    function automatic logic [CMD_W-1:0] class_of(input rpt_t r);
        return {r.fat, r.nf, r.cor};
    endfunction

endpackage

// File: rtl/rpe_status_reg.sv
// Status and source-ID capture for the root port error collector.
// Applies one message per cycle and the software clear mask together.
// First/multiple decisions use the status held before this cycle.
// Assumes msg_sev is held only while msg_valid is high.
module rpe_status_reg
    import rpe_pkg::*;
#(
    parameter int SRC_W = 16,
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  logic [SRC_W-1:0] msg_src,
    input  logic             clr_we,
    input  rpt_t             clr_mask,
    input  logic             vec_load,
    input  logic [VEC_W-1:0] vec_in,
    output rpt_t             rpt,
    output logic [SRC_W-1:0] cor_src,
    output logic [SRC_W-1:0] unc_src,
    output logic [VEC_W-1:0] vector
);

    logic is_cor, is_nf, is_fat, is_unc;
    rpt_t rpt_nxt;

    // Decode the incoming message class.
    always_comb begin
        is_cor = msg_valid && (sev_e'(msg_sev) == SEV_COR);
        is_nf  = msg_valid && (sev_e'(msg_sev) == SEV_NONFATAL);
        is_fat = msg_valid && (sev_e'(msg_sev) == SEV_FATAL);
        is_unc = is_nf || is_fat;
    end

    // Next status: clear by mask, then OR in the bits the message sets.
    always_comb begin
        rpt_nxt = clr_we ? (rpt & ~clr_mask) : rpt;
        if (is_cor) begin
            if (rpt.cor) rpt_nxt.mcor = 1'b1;
            rpt_nxt.cor = 1'b1;
        end
        if (is_nf) rpt_nxt.nf = 1'b1;
        if (is_fat) begin
            if (!rpt.unc) rpt_nxt.ffat = 1'b1;
            rpt_nxt.fat = 1'b1;
        end
        if (is_unc) begin
            if (rpt.unc) rpt_nxt.munc = 1'b1;
            rpt_nxt.unc = 1'b1;
        end
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) rpt <= '0;
        else        rpt <= rpt_nxt;
    end

    // Source ID capture for the first error of each class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cor_src <= '0;
            unc_src <= '0;
        end else begin
            if (is_cor && !rpt.cor) cor_src <= msg_src;
            if (is_unc && !rpt.unc) unc_src <= msg_src;
        end
    end

    // Vector field, loaded only through the side input.
    always_ff @(posedge clk) begin
        if (!rst_n)        vector <= '0;
        else if (vec_load) vector <= vec_in;
    end

    AST_COR_SRC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cor && rpt.cor) |=> $stable(cor_src)); // R2
    AST_UNC_SRC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_unc && rpt.unc) |=> $stable(unc_src)); // R3
    AST_FFAT_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fat && rpt.unc) |=> !$rose(rpt.ffat)); // R4
    AST_VEC_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_load |=> $stable(vector)); // R5

endmodule

// File: rtl/rpe_cfg_port.sv
// Configuration access for the collector: holds the command register,
// decodes writes into status clears and command updates, and muxes reads.
// Assumes DATA_W can hold both source IDs and the vector plus report bits.
module rpe_cfg_port
    import rpe_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int VEC_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  rpt_t              rpt,
    input  logic [SRC_W-1:0]  cor_src,
    input  logic [SRC_W-1:0]  unc_src,
    input  logic [VEC_W-1:0]  vector,
    output logic [CMD_W-1:0]  cmd,
    output logic              cmd_wr,
    output logic [CMD_W-1:0]  cmd_new,
    output logic              clr_we,
    output rpt_t              clr_mask
);

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:RPT_W];

    // Write decode into per-register strobes.
    always_comb begin
        cmd_wr   = cfg_wr && (cfg_addr == ADDR_CMD);
        cmd_new  = cfg_wdata[CMD_W-1:0];
        clr_we   = cfg_wr && (cfg_addr == ADDR_STATUS);
        clr_mask = rpt_t'(cfg_wdata[RPT_W-1:0]);
    end

    // Command register with the three reporting enables.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd <= '0;
        else if (cmd_wr) cmd <= cmd_new;
    end

    // Read mux; unmapped address reads zero.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            ADDR_STATUS: begin
                cfg_rdata[RPT_W-1:0]        = rpt;
                cfg_rdata[DATA_W-1 -: VEC_W] = vector;
            end
            ADDR_CMD: cfg_rdata[CMD_W-1:0] = cmd;
            ADDR_SRC: cfg_rdata[2*SRC_W-1:0] = {unc_src, cor_src};
            default:  cfg_rdata = '0;
        endcase
    end

    AST_CMD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(cmd)); // R6

endmodule

// File: rtl/rpe_irq_gen.sv
// Interrupt generation for the collector. Evaluates the enabled-status
// condition from the status and command held before this cycle, fires on
// message arrival or command writes, and routes to MSI-X, MSI or INTx.
// Assumes rpt and cmd are the registered (pre-update) values.
module rpe_irq_gen
    import rpe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid,
    input  logic [1:0]       msg_sev,
    input  rpt_t             rpt,
    input  logic [CMD_W-1:0] cmd,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_new,
    input  logic             msi_en,
    input  logic             msix_en,
    output logic             intx_level,
    output logic             msi_req,
    output logic             msix_req
);

    logic [CMD_W-1:0] cls;
    logic [CMD_W-1:0] sev_bit;
    logic             was_on, msg_fire, wr_fire, any_fire, legacy;

    // Severity to command-enable bit.
    always_comb begin
        case (sev_e'(msg_sev))
            SEV_COR:      sev_bit = 3'b001;
            SEV_NONFATAL: sev_bit = 3'b010;
            SEV_FATAL:    sev_bit = 3'b100;
            default:      sev_bit = 3'b000;
        endcase
    end

    // Trigger conditions from the previous status and command.
    always_comb begin
        cls      = class_of(rpt);
        was_on   = |(cls & cmd);
        msg_fire = msg_valid && |(sev_bit & cmd) && !was_on;
        wr_fire  = cmd_wr && !was_on && |(cls & cmd_new);
        any_fire = msg_fire || wr_fire;
        legacy   = !msi_en && !msix_en;
    end

    // Message request pulses, MSI-X ahead of MSI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_req  <= 1'b0;
            msix_req <= 1'b0;
        end else begin
            msix_req <= any_fire && msix_en;
            msi_req  <= any_fire && msi_en && !msix_en;
        end
    end

    // Legacy level: recomputed on command writes, raised on message fire.
    always_ff @(posedge clk) begin
        if (!rst_n) intx_level <= 1'b0;
        else if (legacy) begin
            if (cmd_wr)        intx_level <= |(cls & cmd_new) || msg_fire;
            else if (msg_fire) intx_level <= 1'b1;
        end
    end

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(msi_req && msix_req)); // R8
    AST_MSIX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        msix_req |-> $past(msix_en)); // R8
    AST_MSI_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req |-> $past(msi_en && !msix_en)); // R8
    AST_INTX_HOLD_MSG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_en || msix_en) |=> $stable(intx_level)); // R9
    AST_NO_REPEAT_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (was_on && !cmd_wr) |=> !msi_req && !msix_req); // R7

endmodule

// File: rtl/rpe_collector.sv
// Root port error status collector top. Ties the status/source capture,
// the configuration port and the interrupt generator together.
// Assumes messages arrive already gated by the bridges below.
module rpe_collector
    import rpe_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int VEC_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [1:0]        msg_sev,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              vec_load,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic              msi_en,
    input  logic              msix_en,
    output logic              intx_level,
    output logic              msi_req,
    output logic              msix_req,
    output logic [VEC_W-1:0]  irq_vector
);

    rpt_t             rpt;
    rpt_t             clr_mask;
    logic             clr_we;
    logic [SRC_W-1:0] cor_src, unc_src;
    logic [VEC_W-1:0] vector;
    logic [CMD_W-1:0] cmd, cmd_new;
    logic             cmd_wr;

    rpe_status_reg #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .msg_valid(msg_valid),
        .msg_sev  (msg_sev),
        .msg_src  (msg_src),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .vec_load (vec_load),
        .vec_in   (vec_in),
        .rpt      (rpt),
        .cor_src  (cor_src),
        .unc_src  (unc_src),
        .vector   (vector)
    );

    rpe_cfg_port #(.SRC_W(SRC_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .rpt      (rpt),
        .cor_src  (cor_src),
        .unc_src  (unc_src),
        .vector   (vector),
        .cmd      (cmd),
        .cmd_wr   (cmd_wr),
        .cmd_new  (cmd_new),
        .clr_we   (clr_we),
        .clr_mask (clr_mask)
    );

    rpe_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_valid (msg_valid),
        .msg_sev   (msg_sev),
        .rpt       (rpt),
        .cmd       (cmd),
        .cmd_wr    (cmd_wr),
        .cmd_new   (cmd_new),
        .msi_en    (msi_en),
        .msix_en   (msix_en),
        .intx_level(intx_level),
        .msi_req   (msi_req),
        .msix_req  (msix_req)
    );

    assign irq_vector = vector;

endmodule

// File: tb/rpe_collector_bench.sv
// Sweep bench for the root port error status collector.
module rpe_collector_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src = 16'd0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        vec_load = 1'b0;
    logic [4:0]  vec_in = 5'd0;
    logic        msi_en = 1'b0;
    logic        msix_en = 1'b0;
    logic        intx_level, msi_req, msix_req;
    logic [4:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    // Reference state
    logic [6:0]  m_st = '0;
    logic [2:0]  m_cmd = '0;
    logic [15:0] m_cor = '0, m_unc = '0;
    logic [4:0]  m_vec = '0;
    logic        x_intx = 1'b0, x_msi, x_msix;

    always #2 clk = ~clk;

    rpe_collector u_rpe_collector (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev),
        .msg_src(msg_src), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vec_load(vec_load),
        .vec_in(vec_in), .msi_en(msi_en), .msix_en(msix_en),
        .intx_level(intx_level), .msi_req(msi_req), .msix_req(msix_req),
        .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] cls(input logic [6:0] s);
        return {s[6], s[5], s[0]};
    endfunction

    // One cycle of stimulus with reference update and output checks.
    task automatic op(input bit dm, input logic [1:0] sv, input logic [15:0] sr,
                      input bit dw, input logic [1:0] ad, input logic [31:0] wd,
                      input string tag);
        logic [6:0] pre;
        logic [2:0] sb, nc;
        bit mf, wf, legacy;
        @(negedge clk);
        msg_valid = dm; msg_sev = sv; msg_src = sr;
        cfg_wr = dw; cfg_addr = ad; cfg_wdata = wd;
        pre = m_st;
        legacy = !msi_en && !msix_en;
        sb = (sv == 2'd0) ? 3'b001 : (sv == 2'd1) ? 3'b010 : (sv == 2'd2) ? 3'b100 : 3'b000;
        mf = dm && ((sb & m_cmd) != 0) && ((cls(pre) & m_cmd) == 0);
        wf = 1'b0;
        nc = wd[2:0];
        if (dw && ad == 2'd0) m_st = m_st & ~wd[6:0];
        if (dm && sv == 2'd0) begin
            if (pre[0]) m_st[1] = 1'b1; else m_cor = sr;
            m_st[0] = 1'b1;
        end
        if (dm && sv == 2'd1) m_st[5] = 1'b1;
        if (dm && sv == 2'd2) begin
            if (!pre[2]) m_st[4] = 1'b1;
            m_st[6] = 1'b1;
        end
        if (dm && (sv == 2'd1 || sv == 2'd2)) begin
            if (pre[2]) m_st[3] = 1'b1; else m_unc = sr;
            m_st[2] = 1'b1;
        end
        if (dw && ad == 2'd1) begin
            wf = ((cls(pre) & m_cmd) == 0) && ((cls(pre) & nc) != 0);
            if (legacy) x_intx = ((cls(pre) & nc) != 0) || mf;
            m_cmd = nc;
        end else if (legacy && mf) x_intx = 1'b1;
        x_msix = (mf || wf) && msix_en;
        x_msi  = (mf || wf) && msi_en && !msix_en;
        @(negedge clk);
        msg_valid = 1'b0; cfg_wr = 1'b0;
        check({tag, " msix_req"}, {31'd0, msix_req}, {31'd0, x_msix});
        check({tag, " msi_req"}, {31'd0, msi_req}, {31'd0, x_msi});
        check({tag, " intx_level"}, {31'd0, intx_level}, {31'd0, x_intx});
    endtask

    task automatic rd(input logic [1:0] ad, input logic [31:0] exp, input string tag);
        cfg_addr = ad;
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic rd_all(input string tag);
        rd(2'd0, {m_vec, 20'd0, m_st}, {tag, " status"});
        rd(2'd1, {29'd0, m_cmd}, {tag, " command"});
        rd(2'd2, {m_unc, m_cor}, {tag, " source"});
    endtask

    task automatic set_mode(input int md);
        @(negedge clk);
        msi_en  = (md != 0);
        msix_en = (md == 2);
    endtask

    // Clear status and command, leaving INTx low.
    task automatic clean();
        set_mode(0);
        op(0, 0, 0, 1, 2'd0, 32'h7F, "R5 clear");
        op(0, 0, 0, 1, 2'd1, 32'h0, "R9 cmd0");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd_all("R1");
        check("R1 intx", {31'd0, intx_level}, 32'd0);
        check("R1 msi", {31'd0, msi_req}, 32'd0);
        check("R1 msix", {31'd0, msix_req}, 32'd0);

        // R5: vector field loads by side input only
        @(negedge clk); vec_load = 1'b1; vec_in = 5'h15;
        @(negedge clk); vec_load = 1'b0; m_vec = 5'h15;
        check("R5 irq_vector", {27'd0, irq_vector}, {27'd0, m_vec});
        op(0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF, "R5 write all ones");
        rd(2'd0, {m_vec, 20'd0, m_st}, "R5 vector read-only");
        // R6: command readback, upper bits zero
        op(0, 0, 0, 1, 2'd1, 32'hFFFF_FFF5, "R6 cmd write");
        rd(2'd1, 32'd5, "R6 cmd readback");

        // R7 R8 R12: single message against every enable set and mode
        for (int md = 0; md < 3; md++)
            for (int c = 0; c < 8; c++)
                for (int s = 0; s < 4; s++) begin
                    clean();
                    set_mode(md);
                    op(0, 0, 0, 1, 2'd1, c, "R10 setup");
                    op(1, s[1:0], 16'h1000 + 16'(md * 64 + c * 4 + s), 0, 0, 0,
                       (s == 3) ? "R12 ignored" : "R7 R8 message");
                    rd_all((s == 3) ? "R12" : "R2 R3 R4");
                end

        // R2 R3 R4: ordered pairs of messages
        for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++) begin
                clean();
                op(1, a[1:0], 16'hA000 + 16'(a * 3 + b), 0, 0, 0, "R2 first");
                op(1, b[1:0], 16'hB000 + 16'(a * 3 + b), 0, 0, 0, "R3 second");
                rd_all("R2 R3 R4 pair");
                op(0, 0, 0, 1, 2'd0, 32'h1, "R5 partial clear");
                rd(2'd0, {m_vec, 20'd0, m_st}, "R5 partial clear");
            end

        // R9 R10: command writes over every class pattern and enable pair
        for (int md = 0; md < 3; md++)
            for (int p = 0; p < 8; p++)
                for (int o = 0; o < 8; o++)
                    for (int n = 0; n < 8; n++) begin
                        clean();
                        if (p[0]) op(1, 2'd0, 16'h11, 0, 0, 0, "R2 seed");
                        if (p[1]) op(1, 2'd1, 16'h22, 0, 0, 0, "R3 seed");
                        if (p[2]) op(1, 2'd2, 16'h33, 0, 0, 0, "R4 seed");
                        set_mode(md);
                        op(0, 0, 0, 1, 2'd1, o, "R10 old cmd");
                        op(0, 0, 0, 1, 2'd1, n, (md == 0) ? "R9 new cmd" : "R10 new cmd");
                    end

        // R11: message and clear in the same cycle
        clean();
        op(1, 2'd0, 16'hC0C0, 0, 0, 0, "R11 seed");
        op(1, 2'd0, 16'hD0D0, 1, 2'd0, 32'h7F, "R11 collide cor");
        rd_all("R11 cor");
        op(1, 2'd2, 16'hE0E0, 0, 0, 0, "R11 seed unc");
        op(1, 2'd1, 16'hF0F0, 1, 2'd0, 32'h7F, "R11 collide unc");
        rd_all("R11 unc");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule